// File: doc/BRIEF.md
# SPI-Mode Memory Card Bring-Up Sequencer

This block is the host side of a memory card link run in SPI mode. After reset it starts on its own. With chip select held high it clocks out wake-up bytes. It then lowers chip select and sends the reset command as a fixed six-byte frame, and collects the card's one-byte status reply. It repeats the activation command until the card leaves the idle state. Only after that does it raise the serial clock from a slow rate to a fast rate and report that the card is ready.

Once the card is ready, the user side can hand the block a command index and a 32-bit argument. The block frames the command, polls for the status byte and returns it with a one-cycle valid pulse. If any step of the bring-up fails, the block stops and reports one of three error codes. Every shift on the wire is a whole byte. The serial clock idles low, the card samples on the rising edge and the host changes its output on the falling edge.

Top module: `sdspi_boot_ctrl`

## Requirements
- R1: During reset and right after it, `spi_cs_n` is 1, `spi_sck` is 0, and `cmd_ready`, `init_done` and `init_fail` are 0. Before chip select first goes low, exactly DUMMY_BYTES×8 rising clock edges (80 by default) are sent with chip select high.
- R2: A command goes out MSB first as six bytes. Byte 0 is 0x40 OR the 6-bit index. Bytes 1 to 4 are the argument, most significant byte first. Byte 5 is {CRC7, 1}, where CRC7 uses the polynomial x^7+x^3+1 over the first 40 bits.
- R3: The first command after reset is index 0 with argument 0, sent as 40 00 00 00 00 95.
- R4: After the six command bytes the host sends 0xFF bytes. It takes the first received byte whose bit 7 is 0 as the status byte. If no such byte arrives within POLL_MAX (8) bytes, the result is a timeout.
- R5: If the reply to the reset command is not 0x01, bring-up ends with `init_fail`=1 and `fail_code`=1. A timeout on any bring-up reply ends it with `fail_code`=2.
- R6: The activation command (index 1, argument 0) is resent each time it is answered with 0x01, up to RETRY_MAX sends in total. A reply of 0x00 sets `init_done`. If the limit is used up, `fail_code` is 3. Any other reply gives `fail_code`=1.
- R7: Each chip-select-low window holds a whole number of bytes. The window is the command, the poll bytes and exactly one more 0xFF byte, after which chip select rises.
- R8: The clock high time is SLOW_HALF system clocks until `init_done` is set, and FAST_HALF system clocks after that.
- R9: `cmd_ready` is 1 only in the ready state. A `cmd_start` there sends the user's command. When the window ends, `rsp_valid` pulses for one cycle with `rsp_r1` and `rsp_timeout`.
- R10: The serial clock idles low. MOSI does not change while the clock is high, and MISO is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start a user command (used when `cmd_ready`) |
| cmd_index | input | 6 | User command index |
| cmd_arg | input | 32 | User command argument |
| cmd_ready | output | 1 | Block is idle and ready for a user command |
| rsp_valid | output | 1 | One-cycle pulse: user command finished |
| rsp_r1 | output | 8 | Status byte captured for the user command |
| rsp_timeout | output | 1 | No status byte seen within the poll limit |
| init_done | output | 1 | Bring-up finished successfully |
| init_fail | output | 1 | Bring-up stopped on an error |
| fail_code | output | 2 | 1 bad reply, 2 no reply, 3 retries used up |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Host-to-card data |
| spi_miso | input | 1 | Card-to-host data |
| spi_cs_n | output | 1 | Card select, active low |

## Verification
The hardest case to reach from the ports is the end of the activation retry loop. The card has to answer "idle" on every send until the host's own counter runs out. The bench does this with a behavioural card on the SPI pins. Its reply to each decoded command comes from per-scenario settings: a reply to the reset command, a count of idle replies before the final one, a number of filler bytes with bit 7 set, and a mute switch. With these settings a fresh reset reaches the exhausted-retry, bad-reply, no-reply and late-reply paths, and each one is judged from the recorded MOSI bytes, the length of each select window and the clock high times.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

   typedef enum logic [1:0] {
      FAIL_NONE    = 2'd0,
      FAIL_BAD_R1  = 2'd1,
      FAIL_NO_RESP = 2'd2,
      FAIL_RETRY   = 2'd3
   } fail_e;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_DUMMY,
      ST_CMD,
      ST_POLL,
      ST_TAIL,
      ST_DECIDE,
      ST_READY,
      ST_FAIL
   } seq_st_e;

   typedef enum logic [1:0] {
      PH_RESET,
      PH_ACTIVATE,
      PH_USER
   } phase_e;

   // CRC7, polynomial x^7 + x^3 + 1, over a 40-bit header, MSB first
   function automatic logic [6:0] crc7_40(input logic [39:0] d);
      logic [6:0] c;
      logic       fb;
      c = '0;
      for (int i = 39; i >= 0; i--) begin
         fb = d[i] ^ c[6];
         c  = {c[5:0], 1'b0};
         if (fb) c = c ^ 7'h09;
      end
      return c;
   endfunction

endpackage

// File: rtl/sdspi_half_tick.sv
module sdspi_half_tick #(
   parameter int SLOW_HALF = 63,
   parameter int FAST_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic fast,
   output logic tick
);
   localparam int CW = $clog2(SLOW_HALF + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;

   assign lim  = fast ? CW'(FAST_HALF - 1) : CW'(SLOW_HALF - 1);
   assign tick = run && (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run || tick) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/sdspi_byte_shift.sv
module sdspi_byte_shift (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  logic       tick,
   input  logic       miso,
   output logic       busy,
   output logic       done,
   output logic [7:0] rx_byte,
   output logic       sck,
   output logic       mosi
);
   logic [7:0] sh_q;
   logic [7:0] rx_q;
   logic [2:0] bit_q;

   assign mosi    = sh_q[7];
   assign rx_byte = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         sck   <= 1'b0;
         sh_q  <= '1;
         rx_q  <= '0;
         bit_q <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy  <= 1'b1;
            sh_q  <= tx_byte;
            bit_q <= '0;
            sck   <= 1'b0;
         end else if (busy && tick) begin
            if (!sck) begin
               sck  <= 1'b1;
               rx_q <= {rx_q[6:0], miso};
            end else begin
               sck <= 1'b0;
               if (bit_q == 3'd7) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  sh_q  <= {sh_q[6:0], 1'b1};
                  bit_q <= bit_q + 1'b1;
               end
            end
         end
      end
   end

   // R10
   sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);
   // R7
   start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   // R10
   mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));
endmodule

// File: rtl/sdspi_boot_ctrl.sv
module sdspi_boot_ctrl
   import sdspi_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int SLOW_HALF   = 63,
   parameter int FAST_HALF   = 2,
   parameter int DUMMY_BYTES = 10,
   parameter int POLL_MAX    = 8,
   parameter int RETRY_MAX   = 1000,
   parameter bit CRC_GEN     = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_start,
   input  logic [5:0]  cmd_index,
   input  logic [31:0] cmd_arg,
   output logic        cmd_ready,
   output logic        rsp_valid,
   output logic [7:0]  rsp_r1,
   output logic        rsp_timeout,
   output logic        init_done,
   output logic        init_fail,
   output logic [1:0]  fail_code,
   output logic        spi_sck,
   output logic        spi_mosi,
   input  logic        spi_miso,
   output logic        spi_cs_n
);
   localparam int BMAX = (DUMMY_BYTES > 6) ? DUMMY_BYTES : 6;
   localparam int BW   = $clog2(BMAX) + 1;
   localparam int PW   = $clog2(POLL_MAX) + 1;
   localparam int RW   = $clog2(RETRY_MAX + 1);

   generate
      if (FAST_HALF < 1 || FAST_HALF > SLOW_HALF) begin : g_bad_fast
         $error("FAST_HALF must lie in 1..SLOW_HALF");
      end
      if (CLK_HZ > 800_000 * SLOW_HALF) begin : g_bad_slow
         $error("SLOW_HALF gives a bring-up clock above 400 kHz");
      end
      if (DUMMY_BYTES < 10) begin : g_bad_dummy
         $error("DUMMY_BYTES must give at least 80 wake-up clocks");
      end
      if (POLL_MAX < 1 || RETRY_MAX < 1) begin : g_bad_limits
         $error("POLL_MAX and RETRY_MAX must be at least 1");
      end
   endgenerate

   seq_st_e        state_q;
   phase_e         phase_q;
   logic [BW-1:0]  byte_q;
   logic [PW-1:0]  poll_q;
   logic [RW-1:0]  retry_q;
   logic [47:0]    frame_q;
   logic [7:0]     r1_q;
   logic           tmo_q;
   logic           fast_q;
   logic           x_start;
   logic [7:0]     x_tx;
   logic           x_busy, x_done, tick;
   logic [7:0]     x_rx;

   logic [5:0]  nxt_idx;
   logic [31:0] nxt_arg;
   logic [6:0]  nxt_crc;
   logic [47:0] nxt_frame;

   always_comb begin
      nxt_idx = 6'd1;
      nxt_arg = '0;
      if (state_q == ST_BOOT || state_q == ST_DUMMY) begin
         nxt_idx = 6'd0;
      end else if (state_q == ST_READY) begin
         nxt_idx = cmd_index;
         nxt_arg = cmd_arg;
      end
   end

   generate
      if (CRC_GEN) begin : g_crc_calc
         assign nxt_crc = crc7_40({2'b01, nxt_idx, nxt_arg});
      end else begin : g_crc_const
         assign nxt_crc = (nxt_idx == 6'd0) ? 7'h4A : 7'h7F;
      end
   endgenerate

   assign nxt_frame = {2'b01, nxt_idx, nxt_arg, nxt_crc, 1'b1};
   assign cmd_ready = (state_q == ST_READY);

   sdspi_half_tick #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(x_busy), .fast(fast_q), .tick(tick));

   sdspi_byte_shift u_shift (
      .clk(clk), .rst_n(rst_n), .start(x_start), .tx_byte(x_tx), .tick(tick),
      .miso(spi_miso), .busy(x_busy), .done(x_done), .rx_byte(x_rx),
      .sck(spi_sck), .mosi(spi_mosi));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_BOOT;
         phase_q     <= PH_RESET;
         byte_q      <= '0;
         poll_q      <= '0;
         retry_q     <= '0;
         frame_q     <= '0;
         r1_q        <= '1;
         tmo_q       <= 1'b0;
         fast_q      <= 1'b0;
         x_start     <= 1'b0;
         x_tx        <= '1;
         spi_cs_n    <= 1'b1;
         init_done   <= 1'b0;
         init_fail   <= 1'b0;
         fail_code   <= FAIL_NONE;
         rsp_valid   <= 1'b0;
         rsp_r1      <= '0;
         rsp_timeout <= 1'b0;
      end else begin
         x_start   <= 1'b0;
         rsp_valid <= 1'b0;
         unique case (state_q)
            ST_BOOT: begin
               x_start <= 1'b1;
               x_tx    <= 8'hFF;
               byte_q  <= '0;
               state_q <= ST_DUMMY;
            end
            ST_DUMMY: if (x_done) begin
               x_start <= 1'b1;
               if (byte_q == BW'(DUMMY_BYTES - 1)) begin
                  spi_cs_n <= 1'b0;
                  x_tx     <= nxt_frame[47:40];
                  frame_q  <= nxt_frame << 8;
                  byte_q   <= '0;
                  state_q  <= ST_CMD;
               end else begin
                  x_tx   <= 8'hFF;
                  byte_q <= byte_q + 1'b1;
               end
            end
            ST_CMD: if (x_done) begin
               x_start <= 1'b1;
               if (byte_q == BW'(5)) begin
                  x_tx    <= 8'hFF;
                  poll_q  <= '0;
                  state_q <= ST_POLL;
               end else begin
                  x_tx    <= frame_q[47:40];
                  frame_q <= frame_q << 8;
                  byte_q  <= byte_q + 1'b1;
               end
            end
            ST_POLL: if (x_done) begin
               x_start <= 1'b1;
               x_tx    <= 8'hFF;
               if (!x_rx[7]) begin
                  r1_q    <= x_rx;
                  tmo_q   <= 1'b0;
                  state_q <= ST_TAIL;
               end else if (poll_q == PW'(POLL_MAX - 1)) begin
                  tmo_q   <= 1'b1;
                  state_q <= ST_TAIL;
               end else begin
                  poll_q <= poll_q + 1'b1;
               end
            end
            ST_TAIL: if (x_done) begin
               spi_cs_n <= 1'b1;
               state_q  <= ST_DECIDE;
            end
            ST_DECIDE: begin
               if (phase_q == PH_USER) begin
                  rsp_valid   <= 1'b1;
                  rsp_r1      <= r1_q;
                  rsp_timeout <= tmo_q;
                  state_q     <= ST_READY;
               end else if (tmo_q) begin
                  init_fail <= 1'b1;
                  fail_code <= FAIL_NO_RESP;
                  state_q   <= ST_FAIL;
               end else if (phase_q == PH_RESET && r1_q != 8'h01) begin
                  init_fail <= 1'b1;
                  fail_code <= FAIL_BAD_R1;
                  state_q   <= ST_FAIL;
               end else if (phase_q == PH_ACTIVATE && r1_q == 8'h00) begin
                  init_done <= 1'b1;
                  fast_q    <= 1'b1;
                  state_q   <= ST_READY;
               end else if (phase_q == PH_ACTIVATE && r1_q != 8'h01) begin
                  init_fail <= 1'b1;
                  fail_code <= FAIL_BAD_R1;
                  state_q   <= ST_FAIL;
               end else if (phase_q == PH_ACTIVATE && retry_q == RW'(RETRY_MAX)) begin
                  init_fail <= 1'b1;
                  fail_code <= FAIL_RETRY;
                  state_q   <= ST_FAIL;
               end else begin
                  retry_q  <= (phase_q == PH_RESET) ? RW'(1) : retry_q + 1'b1;
                  phase_q  <= PH_ACTIVATE;
                  spi_cs_n <= 1'b0;
                  x_start  <= 1'b1;
                  x_tx     <= nxt_frame[47:40];
                  frame_q  <= nxt_frame << 8;
                  byte_q   <= '0;
                  state_q  <= ST_CMD;
               end
            end
            ST_READY: if (cmd_start) begin
               phase_q  <= PH_USER;
               spi_cs_n <= 1'b0;
               x_start  <= 1'b1;
               x_tx     <= nxt_frame[47:40];
               frame_q  <= nxt_frame << 8;
               byte_q   <= '0;
               state_q  <= ST_CMD;
            end
            default: ;
         endcase
      end
   end

   // R6
   done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(init_done && init_fail));
   // R9
   ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> init_done);
   // R7
   cs_edge_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(spi_cs_n) || $fell(spi_cs_n)) |-> !x_busy);
   // R4
   poll_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_q < PW'(POLL_MAX));
   // R9
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

// File: tb/sdspi_boot_ctrl_tb_top.sv
module sdspi_boot_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HZ         = 6_000_000;
   localparam int SLOW       = 8;
   localparam int FAST       = 2;
   localparam int DUMMIES    = 10;
   localparam int POLLS      = 8;
   localparam int RETRIES    = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic [5:0]  cmd_index = '0;
   logic [31:0] cmd_arg = '0;
   logic        cmd_ready, rsp_valid, rsp_timeout, init_done, init_fail;
   logic [7:0]  rsp_r1;
   logic [1:0]  fail_code;
   logic        spi_sck, spi_mosi, spi_cs_n;
   logic        miso = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdspi_boot_ctrl #(.CLK_HZ(HZ), .SLOW_HALF(SLOW), .FAST_HALF(FAST),
      .DUMMY_BYTES(DUMMIES), .POLL_MAX(POLLS), .RETRY_MAX(RETRIES), .CRC_GEN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_index(cmd_index),
      .cmd_arg(cmd_arg), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
      .rsp_r1(rsp_r1), .rsp_timeout(rsp_timeout), .init_done(init_done),
      .init_fail(init_fail), .fail_code(fail_code), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(miso), .spi_cs_n(spi_cs_n));

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // ---------------- behavioural card ----------------
   int          r1_cmd0, cmd1_idle, cmd1_final, resp_delay, user_r1, cmd1_seen;
   bit          mute, in_win;
   logic [7:0]  out_q[$];
   logic [7:0]  cur_out, rxs;
   int          bitcnt, cmd_pos, win_cnt, pre_clks, align_err;
   logic [47:0] cmd_acc;
   logic [47:0] cmd_log[$];
   int          win_len[$];

   task automatic card_clear();
      out_q.delete(); cmd_log.delete(); win_len.delete();
      bitcnt = 0; cmd_pos = 0; win_cnt = 0; pre_clks = 0; align_err = 0;
      cmd1_seen = 0; in_win = 1'b0; cur_out = 8'hFF; miso = 1'b1;
   endtask

   function automatic logic [7:0] pop_out();
      if (out_q.size() > 0) return out_q.pop_front();
      return 8'hFF;
   endfunction

   task automatic respond(input logic [5:0] idx);
      logic [7:0] r;
      if (mute) return;
      repeat (resp_delay) out_q.push_back(8'hBF);
      if (idx == 6'd0) r = 8'(r1_cmd0);
      else if (idx == 6'd1) begin
         r = (cmd1_seen < cmd1_idle) ? 8'h01 : 8'(cmd1_final);
         cmd1_seen++;
      end else r = 8'(user_r1);
      out_q.push_back(r);
   endtask

   task automatic card_byte(input logic [7:0] b);
      win_cnt++;
      if (cmd_pos == 0) begin
         if (b[7:6] == 2'b01) begin
            cmd_acc = {40'd0, b};
            cmd_pos = 1;
         end
      end else begin
         cmd_acc = {cmd_acc[39:0], b};
         cmd_pos++;
         if (cmd_pos == 6) begin
            cmd_pos = 0;
            cmd_log.push_back(cmd_acc);
            respond(cmd_acc[45:40]);
         end
      end
   endtask

   always @(negedge spi_cs_n) begin
      in_win  = 1'b1;
      bitcnt  = 0;
      win_cnt = 0;
      cur_out = pop_out();
      miso    = cur_out[7];
   end

   always @(posedge spi_cs_n) begin
      miso = 1'b1;
      if (in_win) begin
         win_len.push_back(win_cnt);
         if (bitcnt % 8 != 0) align_err++;
      end
      in_win = 1'b0;
   end

   always @(posedge spi_sck) begin
      if (spi_cs_n) pre_clks++;
      else begin
         rxs = {rxs[6:0], spi_mosi};
         bitcnt++;
         if (bitcnt % 8 == 0) card_byte(rxs);
      end
   end

   always @(negedge spi_sck) begin
      if (!spi_cs_n) begin
         if (bitcnt % 8 == 0) cur_out = pop_out();
         miso = cur_out[3'(7 - (bitcnt % 8))];
      end
   end

   // ------------- per-clock clock-rate reference -------------
   int hi_run, hi_err, fast_seen;
   always @(negedge clk) begin
      if (!rst_n) hi_run = 0;
      else if (spi_sck) hi_run++;
      else if (hi_run > 0) begin
         if (hi_run != (init_done ? FAST : SLOW)) hi_err++;
         if (init_done) fast_seen++;
         hi_run = 0;
      end
   end

   function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
      logic [39:0] m;
      logic [6:0]  c;
      logic        fb;
      m = {2'b01, idx, arg};
      c = '0;
      for (int i = 39; i >= 0; i--) begin
         fb = m[i] ^ c[6];
         c  = {c[5:0], 1'b0};
         if (fb) c = c ^ 7'h09;
      end
      return {m, c, 1'b1};
   endfunction

   function automatic int count_idx(input int idx);
      int n = 0;
      foreach (cmd_log[i]) if (cmd_log[i][45:40] == 6'(idx)) n++;
      return n;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(spi_cs_n == 1'b1 && spi_sck == 1'b0 && !cmd_ready && !init_done && !init_fail,
          "R1 reset state", {spi_cs_n, spi_sck, cmd_ready, init_done, init_fail}, 5'b10000);
      card_clear();
      hi_err = 0; fast_seen = 0;
      rst_n = 1'b1;
   endtask

   task automatic wait_end();
      int n = 0;
      while (!(init_done || init_fail) && n < 60000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic user_cmd(input logic [5:0] idx, input logic [31:0] arg,
                           output logic [7:0] r1, output logic to);
      int n = 0;
      while (!cmd_ready && n < 20000) begin @(negedge clk); n++; end
      cmd_index = idx; cmd_arg = arg; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      n = 0;
      while (!rsp_valid && n < 20000) begin @(negedge clk); n++; end
      r1 = rsp_r1; to = rsp_timeout;
      @(negedge clk);
      // R9 valid is a single-cycle pulse
      chk(!rsp_valid, "R9 rsp_valid pulse width", rsp_valid, 0);
   endtask

   task automatic cfg(input int c0, input int idle, input int fin, input int dly, input bit mu);
      r1_cmd0 = c0; cmd1_idle = idle; cmd1_final = fin; resp_delay = dly; mute = mu;
      user_r1 = 5;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog (all requirements) actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] r1;
      logic       to;
      int         bad;

      // ---- scenario A: normal bring-up, two idle replies, one filler byte ----
      cfg(1, 2, 0, 1, 1'b0);
      do_reset();
      wait_end();
      chk(pre_clks == DUMMIES * 8, "R1 wake-up clocks with CS high", pre_clks, DUMMIES * 8);
      chk(cmd_log.size() > 0 && cmd_log[0] == 48'h40_0000_0000_95, "R3 reset command bytes",
          cmd_log.size() > 0 ? cmd_log[0] : 0, 48'h40_0000_0000_95);
      chk(cmd_log.size() > 1 && cmd_log[1] == exp_frame(6'd1, 32'd0), "R2 R10 activation frame",
          cmd_log.size() > 1 ? cmd_log[1] : 0, exp_frame(6'd1, 32'd0));
      chk(count_idx(1) == 3, "R6 activation sends", count_idx(1), 3);
      chk(init_done && !init_fail && fail_code == 2'd0, "R6 init_done",
          {init_done, init_fail, fail_code}, 4'b1000);
      bad = 0;
      foreach (win_len[i]) if (win_len[i] != 9) bad++;
      chk(bad == 0 && win_len.size() == 4, "R4 R7 window length with tail byte", bad, 0);
      chk(align_err == 0, "R7 whole bytes per window", align_err, 0);
      chk(hi_err == 0, "R8 slow clock high time", hi_err, 0);
      user_cmd(6'd17, 32'h0000_0200, r1, to);
      chk(r1 == 8'h05 && !to, "R9 user response", {to, r1}, 9'h005);
      chk(cmd_log[cmd_log.size()-1] == exp_frame(6'd17, 32'h200), "R2 user frame",
          cmd_log[cmd_log.size()-1], exp_frame(6'd17, 32'h200));
      chk(fast_seen > 0 && hi_err == 0, "R8 fast clock after ready", hi_err, 0);
      chk(spi_sck == 1'b0 && cmd_ready, "R10 clock idles low when ready", spi_sck, 0);
      mute = 1'b1;
      user_cmd(6'd13, 32'hDEAD_BEEF, r1, to);
      chk(to == 1'b1, "R4 user poll timeout", to, 1);
      chk(win_len[win_len.size()-1] == 6 + POLLS + 1, "R4 R7 timeout window length",
          win_len[win_len.size()-1], 6 + POLLS + 1);

      // ---- scenario B: wrong reply to reset command ----
      cfg(5, 0, 0, 0, 1'b0);
      do_reset();
      wait_end();
      chk(init_fail && fail_code == 2'd1 && !init_done, "R5 bad idle reply code", fail_code, 1);
      chk(cmd_log.size() == 1, "R5 no activation after bad reply", cmd_log.size(), 1);

      // ---- scenario C: card never answers ----
      cfg(1, 0, 0, 0, 1'b1);
      do_reset();
      wait_end();
      chk(init_fail && fail_code == 2'd2, "R5 no-reply code", fail_code, 2);
      chk(win_len.size() == 1 && win_len[0] == 15, "R4 eight poll bytes then tail",
          win_len.size() > 0 ? win_len[0] : 0, 15);

      // ---- scenario D: card stays idle, retries used up ----
      cfg(1, 100, 0, 0, 1'b0);
      do_reset();
      wait_end();
      chk(init_fail && fail_code == 2'd3, "R6 retry exhausted code", fail_code, 3);
      chk(count_idx(1) == RETRIES, "R6 activation send count", count_idx(1), RETRIES);
      chk(hi_err == 0 && !cmd_ready, "R8 no fast clock after failure", hi_err, 0);

      // ---- scenario E: activation answered with an error flag ----
      cfg(1, 1, 4, 3, 1'b0);
      do_reset();
      wait_end();
      chk(init_fail && fail_code == 2'd1, "R6 bad activation reply code", fail_code, 1);
      chk(win_len.size() == 3 && win_len[0] == 6 + 4 + 1, "R4 filler bytes skipped",
          win_len.size() > 0 ? win_len[0] : 0, 11);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule